// File: doc/BRIEF.md
# Read-Mode Data Responder

This block forms the read data returned by a flash target on a 32-bit bus. The bus is modelled as two 16-bit flash chips placed side by side. The flash controller supplies the current read mode, the read address, the access length, the status byte, the per-block lock bitmap and the raw array word. The responder returns the word the bus should see.

In array mode the raw array bytes pass through, cut to the access length. In the three other modes a single 16-bit value is formed first:

- Status mode uses the status byte.
- Identifier mode uses the vendor code, the device code or a block's lock bit.
- Query mode uses a byte of the self-description table. The geometry entries of that table are derived from the size parameters instead of being stored.

That value is then laid onto the byte lanes according to the access length. On a 4-byte read with two chips, the value is mirrored into both halves.

The result is registered, so it appears one clock after the inputs are presented. The read mode is decoded with a `unique case` over the enumerated modes. The output register is updated by its own process, which is the only stored state of the block.

Top module: `flash_rd_responder`

## Requirements
- R1: While reset is asserted, and after it, until the first clock edge with reset released, `rd_data` is 0.
- R2: Array mode (`rd_mode` = 2'b00) returns `array_data` cut to the length: code 2'b00 gives bits [7:0], 2'b01 gives bits [15:0], 2'b10 gives all 32 bits, and the rest is zero.
- R3: Status mode (`rd_mode` = 2'b01) uses the status byte zero-extended to 16 bits as the value.
- R4: Identifier mode (`rd_mode` = 2'b10) indexes by `rd_addr[10:2]`. Index 0 gives 0x0000 and index 1 gives 0xFFFF. Index 2 gives `lock_map` bit number `rd_addr[ADDR_W-1:BLOCK_LOG2]` (the lock bit of the addressed block). Every other index gives 0.
- R5: Query mode (`rd_mode` = 2'b11) indexes by `rd_addr / 4`. The identification bytes are:
  - indices 0x10, 0x11, 0x12 give 0x51, 0x52, 0x59;
  - index 0x13 gives 0x01;
  - index 0x15 gives 0x31;
  - indices 0x31, 0x32, 0x33 give 0x50, 0x52, 0x49.
- R6: The query geometry bytes are computed from the parameters:
  - index 0x27 gives log2 of the per-chip size;
  - indices 0x2D and 0x2E give the erase-block count minus one, low byte then high byte;
  - indices 0x2F and 0x30 give the per-chip block size divided by 256, low byte then high byte.
- R7: The fixed query interface bytes are:
  - index 0x28 gives 0x05;
  - index 0x2A gives `BUF_LOG2 + 1 - NUM_CHIPS` (6 with the defaults);
  - index 0x2C gives 0x01.
- R8: Any query index not named in R5 to R7 gives 0. This includes every index at or above 0x44.
- R9: In the non-array modes, length code 2'b00 returns the value's low byte, and 2'b01 returns the 16-bit value with the upper half zero. Code 2'b10 with two chips returns the value in both halves; with one chip the upper half is zero.
- R10: Length code 2'b11 (unsupported) returns 0 in every mode.
- R11: `rd_data` reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | ADDR_W | Byte address of the read within the flash |
| rd_len | input | 2 | Access length code: 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes, 11 = unsupported |
| rd_mode | input | 2 | Read mode: 00 = array, 01 = status, 10 = identifier, 11 = query |
| status | input | 8 | Current status byte |
| lock_map | input | NUM_BLOCKS | One lock bit per erase block |
| array_data | input | 32 | Raw array word at the read address |
| rd_data | output | 32 | Registered read data |

## Verification
Every result of this block is due exactly one rising edge after its inputs are applied, whatever the mode or length. Nothing is held beyond that single output register. The bench therefore drives a new vector on each falling edge. It compares `rd_data` with its behavioural model on the following falling edge, with one rising edge between. Directed vectors cover each named table index, each identifier index, both lock states, and address bits above the identifier window. A long stream of varied vectors then checks every clock back to back, so that a stale or early output would be seen.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        RM_ARRAY  = 2'b00,
        RM_STATUS = 2'b01,
        RM_IDENT  = 2'b10,
        RM_QUERY  = 2'b11
    } rd_mode_e;

    typedef enum logic [1:0] {
        LEN_B1  = 2'b00,
        LEN_B2  = 2'b01,
        LEN_B4  = 2'b10,
        LEN_BAD = 2'b11
    } rd_len_e;

    localparam int BUS_BYTES     = 4;
    localparam int QUERY_TBL_LEN = 'h44;
    localparam int ID_WIN_LSB    = 2;
    localparam int ID_WIN_MSB    = 10;

endpackage

// File: rtl/rd_query_rom.sv
module rd_query_rom
    import flash_rd_pkg::*;
#(
    parameter int SIZE_LOG2  = 22,
    parameter int BLOCK_LOG2 = 16,
    parameter int NUM_CHIPS  = 2,
    parameter int BUF_LOG2   = 7,
    parameter int IDX_W      = 20
) (
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       q_byte
);

    localparam int CHIP_SHIFT     = NUM_CHIPS - 1;
    localparam int CHIP_SIZE_LOG2 = SIZE_LOG2 - CHIP_SHIFT;
    localparam int NUM_BLOCKS     = 1 << (SIZE_LOG2 - BLOCK_LOG2);
    localparam logic [15:0] BLK_CNT_M1  = 16'(NUM_BLOCKS - 1);
    localparam logic [15:0] CHIP_BLK_U  = 16'((1 << (BLOCK_LOG2 - CHIP_SHIFT)) >> 8);
    localparam logic [7:0]  BUF_EXP     = 8'(BUF_LOG2 + 1 - NUM_CHIPS);
    localparam logic [7:0]  SIZE_EXP    = 8'(CHIP_SIZE_LOG2);

    always_comb begin
        q_byte = 8'h00;
        if (idx < IDX_W'(QUERY_TBL_LEN)) begin
            unique case (idx[6:0])
                7'h10:   q_byte = 8'h51;
                7'h11:   q_byte = 8'h52;
                7'h12:   q_byte = 8'h59;
                7'h13:   q_byte = 8'h01;
                7'h15:   q_byte = 8'h31;
                7'h27:   q_byte = SIZE_EXP;
                7'h28:   q_byte = 8'h05;
                7'h2A:   q_byte = BUF_EXP;
                7'h2C:   q_byte = 8'h01;
                7'h2D:   q_byte = BLK_CNT_M1[7:0];
                7'h2E:   q_byte = BLK_CNT_M1[15:8];
                7'h2F:   q_byte = CHIP_BLK_U[7:0];
                7'h30:   q_byte = CHIP_BLK_U[15:8];
                7'h31:   q_byte = 8'h50;
                7'h32:   q_byte = 8'h52;
                7'h33:   q_byte = 8'h49;
                default: q_byte = 8'h00;
            endcase
        end
    end

endmodule

// File: rtl/rd_ident_decode.sv
module rd_ident_decode
    import flash_rd_pkg::*;
#(
    parameter int NUM_BLOCKS = 64,
    parameter int BLK_IDX_W  = 6
) (
    input  logic [ID_WIN_MSB-ID_WIN_LSB:0] sub_idx,
    input  logic [BLK_IDX_W-1:0]           blk_sel,
    input  logic [NUM_BLOCKS-1:0]          lock_map,
    output logic [15:0]                    id_val
);

    localparam int SUB_W = ID_WIN_MSB - ID_WIN_LSB + 1;

    always_comb begin
        unique case (sub_idx)
            SUB_W'(0): id_val = 16'h0000;
            SUB_W'(1): id_val = 16'hFFFF;
            SUB_W'(2): id_val = {15'h0000, lock_map[blk_sel]};
            default:   id_val = 16'h0000;
        endcase
    end

endmodule

// File: rtl/rd_lane_pack.sv
module rd_lane_pack
    import flash_rd_pkg::*;
#(
    parameter int NUM_CHIPS = 2
) (
    input  logic [15:0] value,
    input  logic [1:0]  len,
    output logic [31:0] word
);

    logic [15:0] upper;

    generate
        if (NUM_CHIPS == 2) begin : g_mirror
            assign upper = value;
        end else begin : g_single
            assign upper = 16'h0000;
        end
    endgenerate

    always_comb begin
        unique case (rd_len_e'(len))
            LEN_B1:  word = {24'h000000, value[7:0]};
            LEN_B2:  word = {16'h0000, value};
            LEN_B4:  word = {upper, value};
            default: word = 32'h00000000;
        endcase
    end

endmodule

// File: rtl/flash_rd_responder.sv
module flash_rd_responder
    import flash_rd_pkg::*;
#(
    parameter int SIZE_LOG2  = 22,
    parameter int BLOCK_LOG2 = 16,
    parameter int NUM_CHIPS  = 2,
    parameter int BUF_LOG2   = 7,
    localparam int ADDR_W     = SIZE_LOG2,
    localparam int BLK_IDX_W  = SIZE_LOG2 - BLOCK_LOG2,
    localparam int NUM_BLOCKS = 1 << BLK_IDX_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [1:0]            rd_len,
    input  logic [1:0]            rd_mode,
    input  logic [7:0]            status,
    input  logic [NUM_BLOCKS-1:0] lock_map,
    input  logic [31:0]           array_data,
    output logic [31:0]           rd_data
);

    localparam int IDX_W = ADDR_W - ID_WIN_LSB;

    rd_mode_e    mode;
    logic [7:0]  q_byte;
    logic [15:0] id_val;
    logic [15:0] mode_val;
    logic [31:0] packed_word;
    logic [31:0] array_word;
    logic [31:0] next_data;
    logic        unused_addr_lsb;

    assign mode            = rd_mode_e'(rd_mode);
    assign unused_addr_lsb = ^rd_addr[ID_WIN_LSB-1:0];

    rd_query_rom #(
        .SIZE_LOG2 (SIZE_LOG2),
        .BLOCK_LOG2(BLOCK_LOG2),
        .NUM_CHIPS (NUM_CHIPS),
        .BUF_LOG2  (BUF_LOG2),
        .IDX_W     (IDX_W)
    ) u_query (
        .idx   (rd_addr[ADDR_W-1:ID_WIN_LSB]),
        .q_byte(q_byte)
    );

    rd_ident_decode #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_IDX_W (BLK_IDX_W)
    ) u_ident (
        .sub_idx (rd_addr[ID_WIN_MSB:ID_WIN_LSB]),
        .blk_sel (rd_addr[ADDR_W-1:BLOCK_LOG2]),
        .lock_map(lock_map),
        .id_val  (id_val)
    );

    always_comb begin
        unique case (mode)
            RM_STATUS: mode_val = {8'h00, status};
            RM_IDENT:  mode_val = id_val;
            RM_QUERY:  mode_val = {8'h00, q_byte};
            default:   mode_val = 16'h0000;
        endcase
    end

    rd_lane_pack #(
        .NUM_CHIPS(NUM_CHIPS)
    ) u_pack (
        .value(mode_val),
        .len  (rd_len),
        .word (packed_word)
    );

    always_comb begin
        unique case (rd_len_e'(rd_len))
            LEN_B1:  array_word = {24'h000000, array_data[7:0]};
            LEN_B2:  array_word = {16'h0000, array_data[15:0]};
            LEN_B4:  array_word = array_data;
            default: array_word = 32'h00000000;
        endcase
    end

    always_comb begin
        unique case (mode)
            RM_ARRAY: next_data = array_word;
            default:  next_data = packed_word;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= 32'h00000000;
        end else begin
            rd_data <= next_data;
        end
    end

endmodule

// File: rtl/flash_rd_checker.sv
module flash_rd_checker #(
    parameter int ADDR_W    = 22,
    parameter int NUM_CHIPS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [1:0]        rd_len,
    input logic [1:0]        rd_mode,
    input logic [7:0]        status,
    input logic [31:0]       rd_data
);

    AST_BAD_LEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len == 2'b11) |=> (rd_data == 32'h0)); // R10

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len == 2'b00) |=> (rd_data[31:8] == 24'h0)); // R9

    AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_len == 2'b01) |=> (rd_data[31:16] == 16'h0)); // R9

    AST_MIRROR_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
        ((NUM_CHIPS == 2) && (rd_mode != 2'b00) && (rd_len == 2'b10))
        |=> (rd_data[31:16] == rd_data[15:0])); // R9

    AST_STATUS_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_mode == 2'b01) && (rd_len == 2'b01))
        |=> (rd_data == {24'h0, $past(status)})); // R3

    AST_IDENT_DEVCODE: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_mode == 2'b10) && (rd_len == 2'b01) && (rd_addr[10:2] == 9'd1))
        |=> (rd_data == 32'h0000FFFF)); // R4

    AST_QUERY_FIRST_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_mode == 2'b11) && (rd_len == 2'b01)
         && (rd_addr[ADDR_W-1:2] == (ADDR_W-2)'(16'h10)))
        |=> (rd_data == 32'h00000051)); // R5

endmodule

bind flash_rd_responder flash_rd_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_CHIPS(NUM_CHIPS)
) u_flash_rd_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_addr(rd_addr),
    .rd_len (rd_len),
    .rd_mode(rd_mode),
    .status (status),
    .rd_data(rd_data)
);

// File: tb/test_flash_rd_responder.sv
module test_flash_rd_responder;

    localparam int CLK_PERIOD = 10;
    localparam int SZ_LOG2    = 22;
    localparam int BLK_LOG2   = 16;
    localparam int CHIPS      = 2;
    localparam int BUFL2      = 7;
    localparam int NBLK       = 1 << (SZ_LOG2 - BLK_LOG2);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [SZ_LOG2-1:0] rd_addr = '0;
    logic [1:0]      rd_len = 2'b00;
    logic [1:0]      rd_mode = 2'b00;
    logic [7:0]      status = 8'h00;
    logic [NBLK-1:0] lock_map = '0;
    logic [31:0]     array_data = 32'h0;
    logic [31:0]     rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_rd_responder #(
        .SIZE_LOG2 (SZ_LOG2),
        .BLOCK_LOG2(BLK_LOG2),
        .NUM_CHIPS (CHIPS),
        .BUF_LOG2  (BUFL2)
    ) i_flash_rd_responder (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .rd_len    (rd_len),
        .rd_mode   (rd_mode),
        .status    (status),
        .lock_map  (lock_map),
        .array_data(array_data),
        .rd_data   (rd_data)
    );

    function automatic logic [7:0] ref_query(input longint idx);
        longint chip_bytes = (longint'(1) << SZ_LOG2) / CHIPS;
        longint blocks     = (longint'(1) << SZ_LOG2) / (longint'(1) << BLK_LOG2);
        longint units      = (longint'(1) << BLK_LOG2) / CHIPS / 256;
        case (idx)
            'h10: return 8'h51;
            'h11: return 8'h52;
            'h12: return 8'h59;
            'h13: return 8'h01;
            'h15: return 8'h31;
            'h27: return 8'($clog2(chip_bytes));
            'h28: return 8'h05;
            'h2A: return 8'(BUFL2 + 1 - CHIPS);
            'h2C: return 8'h01;
            'h2D: return 8'((blocks - 1) % 256);
            'h2E: return 8'((blocks - 1) / 256);
            'h2F: return 8'(units % 256);
            'h30: return 8'(units / 256);
            'h31: return 8'h50;
            'h32: return 8'h52;
            'h33: return 8'h49;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] ref_read(input logic [1:0] m, input logic [1:0] l,
                                             input logic [SZ_LOG2-1:0] a, input logic [7:0] s,
                                             input logic [NBLK-1:0] k, input logic [31:0] d);
        logic [15:0] v;
        longint addr = longint'(a);
        longint sub;
        if (l == 2'b11) return 32'h0;
        if (m == 2'b00) begin
            if (l == 2'b00) return d & 32'h000000FF;
            if (l == 2'b01) return d & 32'h0000FFFF;
            return d;
        end
        if (m == 2'b01) v = {8'h00, s};
        else if (m == 2'b10) begin
            sub = (addr % 2048) / 4;
            if (sub == 0) v = 16'h0000;
            else if (sub == 1) v = 16'hFFFF;
            else if (sub == 2) v = {15'h0, k[addr / (longint'(1) << BLK_LOG2)]};
            else v = 16'h0000;
        end else v = {8'h00, ref_query(addr / 4)};
        if (l == 2'b00) return {24'h0, v[7:0]};
        if (l == 2'b01) return {16'h0, v};
        return (CHIPS == 2) ? {v, v} : {16'h0, v};
    endfunction

    task automatic check(input logic [31:0] exp, input string tag);
        n_tests++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
        end
    endtask

    task automatic apply(input logic [1:0] m, input logic [1:0] l, input logic [SZ_LOG2-1:0] a,
                         input logic [7:0] s, input logic [NBLK-1:0] k, input logic [31:0] d,
                         input string tag);
        logic [31:0] exp;
        rd_mode = m; rd_len = l; rd_addr = a; status = s; lock_map = k; array_data = d;
        exp = ref_read(m, l, a, s, k, d);
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic q(input int idx, input logic [1:0] l, input string tag);
        apply(2'b11, l, SZ_LOG2'(idx * 4), 8'h80, '0, 32'h0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NBLK-1:0] lk;
        rd_mode = 2'b00; rd_len = 2'b10; array_data = 32'hDEADBEEF;
        repeat (3) @(negedge clk);
        check(32'h0, "R1 reset holds zero");
        rst_n = 1'b1;
        check(32'h0, "R1 after release before edge");

        // R2 array mode lengths
        apply(2'b00, 2'b00, '0, 8'h80, '0, 32'hA1B2C3D4, "R2 array byte");
        apply(2'b00, 2'b01, '0, 8'h80, '0, 32'hA1B2C3D4, "R2 array half");
        apply(2'b00, 2'b10, '0, 8'h80, '0, 32'hA1B2C3D4, "R2 array word");
        apply(2'b00, 2'b11, '0, 8'h80, '0, 32'hA1B2C3D4, "R10 array bad length");

        // R3 status
        apply(2'b01, 2'b01, 22'h1234, 8'hB0, '0, 32'h0, "R3 status half");
        apply(2'b01, 2'b10, 22'h1234, 8'h92, '0, 32'h0, "R3 status word mirrored");
        apply(2'b01, 2'b00, 22'h0, 8'h80, '0, 32'h0, "R3 status byte");

        // R4 identifier
        lk = '0; lk[1] = 1'b1;
        apply(2'b10, 2'b01, 22'h000000, 8'h80, lk, 32'h0, "R4 vendor code");
        apply(2'b10, 2'b10, 22'h000004, 8'h80, lk, 32'h0, "R4 device code");
        apply(2'b10, 2'b01, 22'h010008, 8'h80, lk, 32'h0, "R4 locked block");
        apply(2'b10, 2'b01, 22'h000008, 8'h80, lk, 32'h0, "R4 unlocked block");
        apply(2'b10, 2'b10, 22'h010808, 8'h80, lk, 32'h0, "R4 index masks bit 11");
        apply(2'b10, 2'b01, 22'h01000C, 8'h80, lk, 32'h0, "R4 other index");
        apply(2'b10, 2'b11, 22'h000004, 8'h80, lk, 32'h0, "R10 ident bad length");

        // R5 identification bytes
        q('h10, 2'b01, "R5 Q");
        q('h11, 2'b01, "R5 R");
        q('h12, 2'b10, "R5 Y word");
        q('h13, 2'b01, "R5 command set");
        q('h15, 2'b00, "R5 extended table address");
        q('h31, 2'b01, "R5 P");
        q('h32, 2'b01, "R5 R ext");
        q('h33, 2'b10, "R5 I word");

        // R6 geometry
        q('h27, 2'b01, "R6 size exponent");
        q('h2D, 2'b01, "R6 block count low");
        q('h2E, 2'b01, "R6 block count high");
        q('h2F, 2'b01, "R6 block units low");
        q('h30, 2'b10, "R6 block units high");

        // R7 interface bytes
        q('h28, 2'b01, "R7 interface");
        q('h2A, 2'b01, "R7 buffer exponent");
        q('h2C, 2'b10, "R7 region count");

        // R8 unlisted and beyond
        q('h14, 2'b01, "R8 unlisted 0x14");
        q('h20, 2'b10, "R8 unlisted 0x20");
        q('h50, 2'b01, "R8 beyond table");
        apply(2'b11, 2'b01, 22'h3FFFFC, 8'h80, '0, 32'h0, "R8 far index");
        q('h10, 2'b11, "R10 query bad length");
        q('h10, 2'b00, "R9 query byte lane");

        // R11 back-to-back varied vectors
        for (int i = 0; i < 400; i++) begin
            logic [1:0] m = 2'($urandom_range(0, 3));
            logic [1:0] l = 2'($urandom_range(0, 3));
            logic [SZ_LOG2-1:0] a = (i % 3 == 0) ? SZ_LOG2'($urandom)
                                                 : SZ_LOG2'($urandom_range(0, 'h150));
            logic [NBLK-1:0] k = {$urandom, $urandom};
            apply(m, l, a, 8'($urandom), k, $urandom, "R11 R9 stream");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule